// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block connects a single-byte request/acknowledge host port to an 8K x 8 asynchronous static RAM. The RAM side has a 13-bit address bus, separate data-out, data-in and driver-enable signals for the shared 8-bit data bus, and active-low chip-select, output-enable and write-strobe lines. Every RAM timing limit is given in nanoseconds as a parameter. The block rounds each limit up to whole clock periods and generates the strobes from those counts, so no limit is violated at the chosen clock period.

A read pulls chip select and output enable low together. It holds them for the longer of the two access times and captures the byte on the edge that releases them. A write pulls chip select and write strobe low together and keeps output enable high. It drives data for the whole strobe pulse and for a hold interval after the write strobe rises, and chip select stays low through that interval. A recovery gap follows each access: long enough after a read for the RAM to release the bus, and long enough in every case to meet the minimum cycle time. A request that arrives during an access or its gap waits and is accepted on the edge that ends the gap.

Top module: `sram_bus_ctl`

## Requirements
- R1: While reset is held and on the first cycle after it, all three strobes are high (1), the data driver enable is 0 and the done pulse is 0.
- R2: A read drives chip select and output enable low on the edge that accepts the request and keeps them low for max(ceil(100/Tclk), ceil(50/Tclk)) cycles (13 at 8 ns). The write strobe stays high throughout.
- R3: The read byte is sampled on the edge that raises the read strobes. It appears on host_rdata together with a one-cycle host_done (done is 1 for exactly one cycle) and stays there until the next read completes.
- R4: A write drives chip select and the write strobe low on the accepting edge. The write strobe stays low for max(ceil(80/Tclk), ceil(50/Tclk)) cycles (10 at 8 ns), and output enable stays high for the whole write.
- R5: Write data is driven from the falling edge of the write strobe until chip select rises, a further max(ceil(10/Tclk), ceil(5/Tclk), 1) cycles (2 at 8 ns) after the strobe rises. host_done pulses on the edge that raises chip select (12 cycles at 8 ns).
- R6: Address and write data are sampled only on the accepting edge; later changes on the host inputs have no effect on that access. The RAM address stays unchanged for as long as chip select is low.
- R7: The data driver is never enabled while output enable is low. Output enable and the write strobe are never low at the same time.
- R8: After a read, chip select stays high for at least max(ceil(40/Tclk), cycle-time remainder, 1) cycles (5 at 8 ns). After a write, it stays high for at least max(cycle-time remainder, 1) cycles (1 at 8 ns). A request held during an access is accepted on the edge that ends this gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Request level; held until host_done |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 13 | Byte address |
| host_wdata | input | 8 | Write byte |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | 8 | Last byte read |
| ram_addr | output | 13 | RAM address |
| ram_ce_n | output | 1 | RAM chip select, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_we_n | output | 1 | RAM write strobe, active low |
| ram_dq_out | output | 8 | Data toward the RAM |
| ram_dq_oe | output | 1 | Enable of the data bus driver |
| ram_dq_in | input | 8 | Data from the RAM |

## Verification
If the request is driven on a falling edge while the controller is idle, host_done is seen on the 14th falling edge for a read and the 13th for a write. A request queued behind a read sees its done pulse three falling edges later than that. Each access task counts falling edges to the done pulse and compares the count with these figures. The strobe-width and gap monitors latch a length on the first rising edge that samples the strobe released, so the checks wait two cycles after done before reading them. The bench's RAM model returns a poison byte until the read strobes have been low for 12 sampled edges, so a capture taken too early shows up as wrong data.

// File: rtl/sram_ctl_pkg.sv
// Shared types and elaboration-time helpers for the SRAM bus controller.
// Assumes all timing inputs are non-negative integers in nanoseconds.
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_READ,
        PH_WPULSE,
        PH_WHOLD,
        PH_RECOVER
    } phase_t;

    // Round a nanosecond limit up to whole clock periods.
    function automatic int unsigned ns_to_clk(input int unsigned ns, input int unsigned period_ns);
        return (ns + period_ns - 1) / period_ns;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Remainder of a minimum period after an active span, floored at zero.
    function automatic int unsigned rem_u(input int unsigned total, input int unsigned used);
        return (total > used) ? (total - used) : 0;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
// Loadable down-counter that times each phase of an access.
// Assumes load values are phase length minus one; expired is high at zero.
module sram_phase_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt;

    // Count down toward zero; a load restarts the phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/sram_strobe_fsm.sv
// Access sequencer: picks the phase, loads the timer and registers the
// RAM strobes and data-driver enable from the next phase.
// Assumes phase lengths are at least one cycle and fit in CNT_W bits.
module sram_strobe_fsm
    import sram_ctl_pkg::*;
#(
    parameter int unsigned CNT_W    = 4,
    parameter int unsigned RD_ACT   = 13,
    parameter int unsigned WR_PULSE = 10,
    parameter int unsigned WR_HOLD  = 2,
    parameter int unsigned RD_GAP   = 5,
    parameter int unsigned WR_GAP   = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             req_write,
    input  logic             expired,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output logic             launch,
    output logic             capture,
    output logic             ce_n,
    output logic             oe_n,
    output logic             we_n,
    output logic             drive_en,
    output logic             done
);

    phase_t state, nxt;
    logic   finish;
    logic   can_start;

    assign can_start = (state == PH_IDLE) || ((state == PH_RECOVER) && expired);

    // Next phase, timer reload and one-cycle actions.
    always_comb begin
        nxt      = state;
        load     = 1'b0;
        load_val = '0;
        launch   = 1'b0;
        capture  = 1'b0;
        finish   = 1'b0;
        if (can_start) begin
            if (req) begin
                launch = 1'b1;
                load   = 1'b1;
                if (req_write) begin
                    nxt      = PH_WPULSE;
                    load_val = CNT_W'(WR_PULSE - 1);
                end else begin
                    nxt      = PH_READ;
                    load_val = CNT_W'(RD_ACT - 1);
                end
            end else begin
                nxt = PH_IDLE;
            end
        end else begin
            case (state)
                PH_READ: if (expired) begin
                    capture  = 1'b1;
                    finish   = 1'b1;
                    nxt      = PH_RECOVER;
                    load     = 1'b1;
                    load_val = CNT_W'(RD_GAP - 1);
                end
                PH_WPULSE: if (expired) begin
                    nxt      = PH_WHOLD;
                    load     = 1'b1;
                    load_val = CNT_W'(WR_HOLD - 1);
                end
                PH_WHOLD: if (expired) begin
                    finish   = 1'b1;
                    nxt      = PH_RECOVER;
                    load     = 1'b1;
                    load_val = CNT_W'(WR_GAP - 1);
                end
                default: nxt = state;
            endcase
        end
    end

    // Phase register and strobes registered from the next phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= PH_IDLE;
            ce_n     <= 1'b1;
            oe_n     <= 1'b1;
            we_n     <= 1'b1;
            drive_en <= 1'b0;
            done     <= 1'b0;
        end else begin
            state    <= nxt;
            ce_n     <= !((nxt == PH_READ) || (nxt == PH_WPULSE) || (nxt == PH_WHOLD));
            oe_n     <= !(nxt == PH_READ);
            we_n     <= !(nxt == PH_WPULSE);
            drive_en <= (nxt == PH_WPULSE) || (nxt == PH_WHOLD);
            done     <= finish;
        end
    end

    // Checker counters: length of the current low run of each strobe.
    logic [CNT_W:0] we_run;
    logic [CNT_W:0] oe_run;

    // Track how many cycles each strobe has been low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_run <= '0;
            oe_run <= '0;
        end else begin
            we_run <= we_n ? '0 : we_run + 1'b1;
            oe_run <= oe_n ? '0 : oe_run + 1'b1;
        end
    end

    assert_we_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (we_run == (CNT_W+1)'(WR_PULSE)));

    assert_rd_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_n) |-> (oe_run == (CNT_W+1)'(RD_ACT)));

    assert_no_oe_in_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> oe_n);

    assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/sram_data_path.sv
// Address and write-data launch registers and the read-capture register.
// Assumes launch and capture are single-cycle strobes from the sequencer.
module sram_data_path #(
    parameter int unsigned ADDR_W = 13,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              capture,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [DATA_W-1:0] ram_dq_in,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_dq_out,
    output logic [DATA_W-1:0] host_rdata
);

    // Sample host fields on acceptance; keep them for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_addr   <= '0;
            ram_dq_out <= '0;
        end else if (launch) begin
            ram_addr   <= host_addr;
            ram_dq_out <= host_wdata;
        end
    end

    // Capture the RAM byte at the end of the read window.
    always_ff @(posedge clk) begin
        if (!rst_n)
            host_rdata <= '0;
        else if (capture)
            host_rdata <= ram_dq_in;
    end

    assert_rdata_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(host_rdata));

endmodule

// File: rtl/sram_bus_ctl.sv
// Top of the asynchronous SRAM controller. Converts nanosecond limits into
// cycle counts and wires the timer, sequencer and data path together.
// Assumes a synchronous host that holds its request fields until accepted.
module sram_bus_ctl
    import sram_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W      = 13,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned CLK_NS      = 8,
    parameter int unsigned T_CYCLE_NS  = 100,
    parameter int unsigned T_WPULSE_NS = 80,
    parameter int unsigned T_DSETUP_NS = 50,
    parameter int unsigned T_DHOLD_NS  = 5,
    parameter int unsigned T_AHOLD_NS  = 10,
    parameter int unsigned T_CEACC_NS  = 100,
    parameter int unsigned T_OEACC_NS  = 50,
    parameter int unsigned T_OEOFF_NS  = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_write,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_done,
    output logic [DATA_W-1:0] host_rdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_ce_n,
    output logic              ram_oe_n,
    output logic              ram_we_n,
    output logic [DATA_W-1:0] ram_dq_out,
    output logic              ram_dq_oe,
    input  logic [DATA_W-1:0] ram_dq_in
);

    localparam int unsigned C_CYC  = ns_to_clk(T_CYCLE_NS, CLK_NS);
    localparam int unsigned C_WP   = ns_to_clk(T_WPULSE_NS, CLK_NS);
    localparam int unsigned C_DS   = ns_to_clk(T_DSETUP_NS, CLK_NS);
    localparam int unsigned C_DH   = ns_to_clk(T_DHOLD_NS, CLK_NS);
    localparam int unsigned C_AH   = ns_to_clk(T_AHOLD_NS, CLK_NS);
    localparam int unsigned C_CEA  = ns_to_clk(T_CEACC_NS, CLK_NS);
    localparam int unsigned C_OEA  = ns_to_clk(T_OEACC_NS, CLK_NS);
    localparam int unsigned C_OFF  = ns_to_clk(T_OEOFF_NS, CLK_NS);

    localparam int unsigned RD_ACT   = max_u(max_u(C_CEA, C_OEA), 1);
    localparam int unsigned WR_PULSE = max_u(max_u(C_WP, C_DS), 1);
    localparam int unsigned WR_HOLD  = max_u(max_u(C_AH, C_DH), 1);
    localparam int unsigned WR_ACT   = WR_PULSE + WR_HOLD;
    localparam int unsigned RD_GAP   = max_u(max_u(C_OFF, rem_u(C_CYC, RD_ACT)), 1);
    localparam int unsigned WR_GAP   = max_u(rem_u(C_CYC, WR_ACT), 1);
    localparam int unsigned MAX_LEN  = max_u(max_u(max_u(RD_ACT, WR_PULSE), max_u(WR_HOLD, RD_GAP)), WR_GAP);
    localparam int unsigned CNT_W    = $clog2(MAX_LEN + 1);

    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic             t_expired;
    logic             launch;
    logic             capture;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_expired)
    );

    sram_strobe_fsm #(
        .CNT_W    (CNT_W),
        .RD_ACT   (RD_ACT),
        .WR_PULSE (WR_PULSE),
        .WR_HOLD  (WR_HOLD),
        .RD_GAP   (RD_GAP),
        .WR_GAP   (WR_GAP)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (host_req),
        .req_write (host_write),
        .expired   (t_expired),
        .load      (t_load),
        .load_val  (t_val),
        .launch    (launch),
        .capture   (capture),
        .ce_n      (ram_ce_n),
        .oe_n      (ram_oe_n),
        .we_n      (ram_we_n),
        .drive_en  (ram_dq_oe),
        .done      (host_done)
    );

    sram_data_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .capture    (capture),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .ram_dq_in  (ram_dq_in),
        .ram_addr   (ram_addr),
        .ram_dq_out (ram_dq_out),
        .host_rdata (host_rdata)
    );

    assert_addr_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_ce_n |=> (ram_ce_n || $stable(ram_addr)));

    assert_no_contention_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ram_dq_oe |-> (ram_oe_n && !ram_ce_n));

    assert_done_on_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |-> (ram_ce_n && !ram_dq_oe));

endmodule

// File: tb/sram_bus_ctl_test.sv
// Directed bench for sram_bus_ctl with a behavioural RAM model.
module sram_bus_ctl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_write = 1'b0;
    logic [12:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_done;
    logic [7:0]  host_rdata;
    logic [12:0] ram_addr;
    logic        ram_ce_n, ram_oe_n, ram_we_n, ram_dq_oe;
    logic [7:0]  ram_dq_out;
    logic [7:0]  ram_dq_in;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    sram_bus_ctl uut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_write(host_write),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_done(host_done),
        .host_rdata(host_rdata), .ram_addr(ram_addr), .ram_ce_n(ram_ce_n),
        .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n), .ram_dq_out(ram_dq_out),
        .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_dq_in)
    );

    // RAM model: 256 bytes on the low address bits, poison until access time.
    logic [7:0] mem [256];
    int         rd_low = 0;
    logic       pend_v = 1'b0;
    logic [7:0] pend_a, pend_d;

    always @(posedge clk) begin
        rd_low <= (!ram_ce_n && !ram_oe_n) ? rd_low + 1 : 0;
        if (!ram_ce_n && !ram_we_n) begin
            pend_a <= ram_addr[7:0];
            pend_d <= ram_dq_oe ? ram_dq_out : 8'h00;
            pend_v <= 1'b1;
        end else if (pend_v) begin
            mem[pend_a] <= pend_d;
            pend_v <= 1'b0;
        end
    end

    always_comb
        ram_dq_in = (!ram_ce_n && !ram_oe_n && ram_we_n && rd_low >= 12) ? mem[ram_addr[7:0]] : 8'hEE;

    // Strobe monitors: latch each low run and each chip-select gap.
    int ce_lo = 0, ce_hi = 0, we_lo = 0, oe_lo = 0, drv = 0;
    int last_ce_lo = 0, last_gap = 0, last_we_lo = 0, last_oe_lo = 0, last_drv = 0;
    logic [12:0] launch_addr = '0;
    logic [12:0] prev_addr = '0;
    int contention = 0, addr_move = 0, oe_we_both = 0;

    always @(posedge clk) begin
        if (rst_n) begin
            if (!ram_ce_n) begin
                if (ce_hi != 0) begin last_gap <= ce_hi; ce_hi <= 0; launch_addr <= ram_addr; end
                else if (ram_addr != prev_addr) addr_move <= addr_move + 1;
                ce_lo <= ce_lo + 1;
            end else begin
                if (ce_lo != 0) begin last_ce_lo <= ce_lo; ce_lo <= 0; end
                ce_hi <= ce_hi + 1;
            end
            if (!ram_we_n) we_lo <= we_lo + 1;
            else if (we_lo != 0) begin last_we_lo <= we_lo; we_lo <= 0; end
            if (!ram_oe_n) oe_lo <= oe_lo + 1;
            else if (oe_lo != 0) begin last_oe_lo <= oe_lo; oe_lo <= 0; end
            if (ram_dq_oe) drv <= drv + 1;
            else if (drv != 0) begin last_drv <= drv; drv <= 0; end
            if (ram_dq_oe && !ram_oe_n) contention <= contention + 1;
            if (!ram_we_n && !ram_oe_n) oe_we_both <= oe_we_both + 1;
            prev_addr <= ram_addr;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One access from idle; returns read byte and falling edges to done.
    task automatic access(input logic wr, input logic [12:0] a, input logic [7:0] d,
                          output logic [7:0] rd, output int lat);
        @(negedge clk);
        host_req = 1'b1; host_write = wr; host_addr = a; host_wdata = d;
        lat = 0;
        do begin @(negedge clk); lat++; end while (!host_done && lat < 200);
        rd = host_rdata;
        host_req = 1'b0;
        if (lat >= 200) check(1'b0, "R3 timeout", lat, 0);
    endtask

    task automatic t_reset;
        check(ram_ce_n && ram_oe_n && ram_we_n, "R1 strobes", {ram_ce_n, ram_oe_n, ram_we_n}, 3'b111);
        check(!ram_dq_oe, "R1 driver", ram_dq_oe, 0);
        check(!host_done, "R1 done", host_done, 0);
    endtask

    task automatic t_write_then_read;
        logic [7:0] rd; int lat;
        access(1'b1, 13'h0A5, 8'h3C, rd, lat);
        check(lat == 13, "R5 write latency", lat, 13);
        repeat (2) @(negedge clk);
        check(last_we_lo == 10, "R4 write strobe width", last_we_lo, 10);
        check(last_drv == 12, "R5 drive span", last_drv, 12);
        check(last_ce_lo == 12, "R5 chip select span", last_ce_lo, 12);
        check(launch_addr == 13'h0A5, "R6 launched address", launch_addr, 13'h0A5);
        access(1'b0, 13'h0A5, 8'h00, rd, lat);
        check(lat == 14, "R3 read latency", lat, 14);
        check(rd == 8'h3C, "R3 read data", rd, 8'h3C);
        @(negedge clk);
        check(!host_done, "R3 done one cycle", host_done, 0);
        @(negedge clk);
        check(last_oe_lo == 13, "R2 output enable width", last_oe_lo, 13);
        check(last_ce_lo == 13, "R2 chip select width", last_ce_lo, 13);
    endtask

    task automatic t_queued_after_read;
        logic [7:0] rd; int lat;
        repeat (8) @(negedge clk);
        access(1'b0, 13'h0A5, 8'h00, rd, lat);
        access(1'b1, 13'h011, 8'h96, rd, lat);
        check(lat == 16, "R8 held-off write latency", lat, 16);
        check(last_gap == 5, "R8 gap after read", last_gap, 5);
        check(host_rdata == 8'h3C, "R3 rdata held across write", host_rdata, 8'h3C);
    endtask

    task automatic t_chained_write_read;
        int lat;
        repeat (8) @(negedge clk);
        @(negedge clk);
        host_req = 1'b1; host_write = 1'b1; host_addr = 13'h022; host_wdata = 8'hC3;
        lat = 0;
        do begin @(negedge clk); lat++; end while (!host_done && lat < 200);
        host_write = 1'b0; host_addr = 13'h022;
        lat = 0;
        do begin @(negedge clk); lat++; end while (!host_done && lat < 200);
        host_req = 1'b0;
        check(lat == 14, "R8 chained read latency", lat, 14);
        check(last_gap == 1, "R8 gap after write", last_gap, 1);
        check(host_rdata == 8'hC3, "R3 chained read data", host_rdata, 8'hC3);
    endtask

    task automatic t_boundaries;
        logic [7:0] rd; int lat;
        access(1'b1, 13'h0000, 8'h5E, rd, lat);
        access(1'b1, 13'h1FFF, 8'hA1, rd, lat);
        repeat (2) @(negedge clk);
        check(launch_addr == 13'h1FFF, "R6 top address", launch_addr, 13'h1FFF);
        access(1'b0, 13'h0000, 8'h00, rd, lat);
        check(rd == 8'h5E, "R3 bottom address data", rd, 8'h5E);
        access(1'b0, 13'h1FFF, 8'h00, rd, lat);
        check(rd == 8'hA1, "R3 top address data", rd, 8'hA1);
    endtask

    task automatic t_late_field_change;
        logic [7:0] rd; int lat;
        access(1'b1, 13'h044, 8'h77, rd, lat);
        @(negedge clk);
        host_req = 1'b1; host_write = 1'b1; host_addr = 13'h033; host_wdata = 8'h5A;
        repeat (3) @(negedge clk);
        host_req = 1'b0; host_addr = 13'h044; host_wdata = 8'hFF;
        lat = 0;
        do begin @(negedge clk); lat++; end while (!host_done && lat < 200);
        access(1'b0, 13'h033, 8'h00, rd, lat);
        check(rd == 8'h5A, "R6 sampled write data", rd, 8'h5A);
        access(1'b0, 13'h044, 8'h00, rd, lat);
        check(rd == 8'h77, "R6 untouched address", rd, 8'h77);
    endtask

    task automatic t_bus_safety;
        repeat (2) @(negedge clk);
        check(contention == 0, "R7 driver with output enable", contention, 0);
        check(oe_we_both == 0, "R7 output enable during write", oe_we_both, 0);
        check(addr_move == 0, "R6 address moved under chip select", addr_move, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_then_read();
        t_queued_after_read();
        t_chained_write_read();
        t_boundaries();
        t_late_field_change();
        t_bus_safety();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog R8 actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule